// File: doc/BRIEF.md
# Multiplexed Burst Bus Sequencer

This block runs a 32-bit external bus that carries address and data on the same wires, on behalf of one internal requester. A request gives a byte address, a read or write flag, a port width (8, 16 or 32 bits) and a length of one to four beats. The block drives one address cycle and then one data cycle per beat. Each beat is paced by an external ready input.

During the address cycle the shared bus holds the word address. The beat count is encoded into the two lowest bus bits. The block pulses an active-low address strobe and an active-high latch enable, and it also drives the inverse of the latch enable. A separate two-bit partial address output steps forward on every ready pulse. For narrow ports the lowest address bits are carried on the byte-enable outputs.

Read data is returned with a one-cycle valid pulse. Write data is taken from the requester, and the block asks for the next word when each beat completes. A halt input parks the bus on defined values, and those values depend on whether the last transfer was a read or a write. A hold input floats the control strobes while the block is idle.

Top module: `mbus_master`

## Requirements
- R1: In the address cycle `busAd[31:2]` equals `reqAddr[31:2]` and `busAd[1:0]` equals `reqLen`, which is the beat count minus one. `busAdOe` is 1.
- R2: `adsN` is low for exactly the one address cycle of each accepted request. `ale` is high in that same cycle only, and `aleN` is always the inverse of `ale`. Out of reset `adsN`=1, `ale`=0 and `aleN`=1.
- R3: A burst completes after `reqLen`+1 cycles with `rdy` high. If a request is valid at the last ready and halt is low, it is accepted (`reqAck`) in that cycle and its address cycle follows immediately. Otherwise the block returns to idle with the bus floating.
- R4: Width is encoded as `reqWidth` 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. The internal partial address P[3:0] starts at `reqAddr[3:0]`, with bit 0 cleared for 16-bit ports and bits 1:0 cleared for 32-bit ports. P advances by 1, 2 or 4 on each ready. `aHi` = P[3:2].
  - For an 8-bit port, `beOut[1:0]` = P[1:0].
  - For a 16-bit port, `beOut[1]` = P[1].
  - All other `beOut` bits are 0.
- R5: In a write data cycle `busAd` equals `wrData` with the lanes beyond the port width forced to 0. `busAdOe` is 1. `wrNext` is high in each cycle in which `rdy` is sampled during a write beat.
- R6: On a read, the cycle after each sampled `rdy` has `rdValid`=1 and `rdData` equal to the sampled `busAdIn`, with the lanes beyond the port width zeroed.
- R7: If P's start plus (beats × step) exceeds 16, the request would cross an aligned 16-byte block. Such a request gets `reqAck` and `reqErr` together and no address cycle.
- R8: In halt after a write, `busAd[31:2]` holds the last driven write word's bits 31:2 and `busAd[1:0]` holds that transfer's length code. `busAdOe` is 1.
- R9: In halt after a read, `busAd` = {last address[31:4], `aHi` of the last data cycle, length code}.
- R10: Halt raised in idle takes effect on the next cycle. Halt raised during a burst lets the burst finish and then enters halt directly. Dropping halt returns the block to idle with `busAdOe`=0.
- R11: While `holdReq` is high in idle, `ctlOe` is 0 and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | 32 | Byte address of first beat |
| reqWrite | input | 1 | 1 = write |
| reqWidth | input | 2 | Port width code |
| reqLen | input | 2 | Beats minus one |
| reqAck | output | 1 | Request consumed this cycle |
| reqErr | output | 1 | Consumed request rejected |
| wrData | input | 32 | Write data for the current beat |
| wrNext | output | 1 | Current write beat done, present the next word |
| rdData | output | 32 | Captured read data |
| rdValid | output | 1 | Read data valid pulse |
| halt | input | 1 | Halt request |
| holdReq | input | 1 | Float control strobes when idle |
| rdy | input | 1 | External ready |
| busAdIn | input | 32 | Shared bus input |
| busAd | output | 32 | Shared bus output |
| busAdOe | output | 1 | Shared bus drive enable |
| ctlOe | output | 1 | Strobe drive enable |
| adsN | output | 1 | Address strobe, active low |
| ale | output | 1 | Latch enable |
| aleN | output | 1 | Inverted latch enable |
| aHi | output | 2 | Partial address bits 3:2 |
| beOut | output | 4 | Byte enables carrying low address bits |

## Verification
Acknowledge, error and the hold float respond in the same cycle as the request inputs. The address cycle appears one clock after acceptance. Bus drive, `wrNext`, `aHi` and `beOut` in a data cycle follow `rdy` in that same cycle. Read data and its valid pulse arrive one clock after the sampled ready, and halt values appear one clock after halt is raised in idle or after the final beat. The bench drives inputs on the falling edge and checks 1 ns later, so every check lands in the cycle the result is due.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int PART_W = 4;
  localparam logic [PART_W:0] SPAN = 5'd16;

  localparam logic [1:0] W8  = 2'd0;
  localparam logic [1:0] W16 = 2'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_HALT} busSt_t;

  typedef struct packed {
    logic load;
    logic beat;
    logic inAddr;
    logic inData;
    logic inHalt;
  } ctlStb_t;

  function automatic logic [PART_W:0] stepOf(input logic [1:0] w);
    case (w)
      W8:      return 5'd1;
      W16:     return 5'd2;
      default: return 5'd4;
    endcase
  endfunction

  function automatic logic [PART_W-1:0] alignPart(input logic [PART_W-1:0] a, input logic [1:0] w);
    case (w)
      W8:      return a;
      W16:     return {a[3:1], 1'b0};
      default: return {a[3:2], 2'b00};
    endcase
  endfunction

  function automatic int unsigned lanesOf(input logic [1:0] w);
    case (w)
      W8:      return 1;
      W16:     return 2;
      default: return LANES;
    endcase
  endfunction
endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqOk,
  input  logic    lastBeat,
  input  logic    rdy,
  input  logic    halt,
  input  logic    holdReq,
  output ctlStb_t stb,
  output logic    reqAck,
  output logic    reqErr,
  output logic    adsN,
  output logic    ale,
  output logic    aleN,
  output logic    ctlOe
);
  busSt_t st, nxt;
  logic canStart, takeReq;

  always_comb begin
    nxt      = st;
    takeReq  = 1'b0;
    canStart = reqValid && !halt && !holdReq;
    case (st)
      ST_IDLE:
        if (halt) nxt = ST_HALT;
        else if (canStart) begin
          takeReq = 1'b1;
          nxt     = reqOk ? ST_ADDR : ST_IDLE;
        end
      ST_ADDR: nxt = ST_DATA;
      ST_DATA:
        if (rdy && lastBeat) begin
          if (halt) nxt = ST_HALT;
          else if (canStart) begin
            takeReq = 1'b1;
            nxt     = reqOk ? ST_ADDR : ST_IDLE;
          end else nxt = ST_IDLE;
        end
      ST_HALT: if (!halt) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;

  assign reqAck     = takeReq;
  assign reqErr     = takeReq && !reqOk;
  assign stb.load   = takeReq && reqOk;
  assign stb.beat   = (st == ST_DATA) && rdy;
  assign stb.inAddr = (st == ST_ADDR);
  assign stb.inData = (st == ST_DATA);
  assign stb.inHalt = (st == ST_HALT);
  assign adsN       = !(st == ST_ADDR);
  assign ale        = (st == ST_ADDR);
  assign aleN       = !ale;
  assign ctlOe      = !((st == ST_IDLE) && holdReq);
endmodule

// File: rtl/mbus_dpath.sv
module mbus_dpath
  import mbus_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStb_t          stb,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic             reqWrite,
  input  logic [1:0]       reqWidth,
  input  logic [1:0]       reqLen,
  input  logic [BUS_W-1:0] wrData,
  input  logic [BUS_W-1:0] busAdIn,
  output logic             reqOk,
  output logic             lastBeat,
  output logic             wrNext,
  output logic [BUS_W-1:0] busAd,
  output logic             busAdOe,
  output logic [1:0]       aHi,
  output logic [LANES-1:0] beOut,
  output logic [BUS_W-1:0] rdData,
  output logic             rdValid
);
  logic [BUS_W-1:2]  addrQ;
  logic              wrQ;
  logic [1:0]        widthQ, sizeQ, beatsLeft;
  logic [PART_W-1:0] partQ;
  logic [BUS_W-1:0]  haltQ, laneMask, wrDrive;
  logic [PART_W:0]   endOff;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneMask[8*i +: 8] = {8{i < lanesOf(widthQ)}};
  end

  assign wrDrive  = wrData & laneMask;
  assign endOff   = {1'b0, alignPart(reqAddr[PART_W-1:0], reqWidth)}
                  + (({3'b000, reqLen} + 5'd1) * stepOf(reqWidth));
  assign reqOk    = endOff <= SPAN;
  assign lastBeat = beatsLeft == 2'd0;
  assign wrNext   = stb.beat && wrQ;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      addrQ <= '0; wrQ <= 1'b0; widthQ <= 2'd2; sizeQ <= '0; beatsLeft <= '0;
      partQ <= '0; haltQ <= '0; rdData <= '0; rdValid <= 1'b0;
    end else begin
      rdValid <= stb.beat && !wrQ;
      if (stb.beat && !wrQ) rdData <= busAdIn & laneMask;
      if (stb.beat)
        haltQ <= wrQ ? {wrDrive[BUS_W-1:2], sizeQ} : {addrQ[BUS_W-1:4], partQ[3:2], sizeQ};
      if (stb.load) begin
        addrQ     <= reqAddr[BUS_W-1:2];
        wrQ       <= reqWrite;
        widthQ    <= reqWidth;
        sizeQ     <= reqLen;
        beatsLeft <= reqLen;
        partQ     <= alignPart(reqAddr[PART_W-1:0], reqWidth);
      end else if (stb.beat) begin
        beatsLeft <= beatsLeft - 2'd1;
        partQ     <= partQ + PART_W'(stepOf(widthQ));
      end
    end

  always_comb begin
    busAd   = '0;
    busAdOe = 1'b0;
    if (stb.inAddr) begin
      busAd   = {addrQ, sizeQ};
      busAdOe = 1'b1;
    end else if (stb.inData) begin
      busAd   = wrQ ? wrDrive : '0;
      busAdOe = wrQ;
    end else if (stb.inHalt) begin
      busAd   = haltQ;
      busAdOe = 1'b1;
    end
  end

  assign aHi = partQ[3:2];

  always_comb begin
    beOut = '0;
    case (widthQ)
      W8:      beOut[1:0] = partQ[1:0];
      W16:     beOut[1]   = partQ[1];
      default: ;
    endcase
  end
endmodule

// File: rtl/mbus_master.sv
module mbus_master
  import mbus_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic             reqWrite,
  input  logic [1:0]       reqWidth,
  input  logic [1:0]       reqLen,
  output logic             reqAck,
  output logic             reqErr,
  input  logic [BUS_W-1:0] wrData,
  output logic             wrNext,
  output logic [BUS_W-1:0] rdData,
  output logic             rdValid,
  input  logic             halt,
  input  logic             holdReq,
  input  logic             rdy,
  input  logic [BUS_W-1:0] busAdIn,
  output logic [BUS_W-1:0] busAd,
  output logic             busAdOe,
  output logic             ctlOe,
  output logic             adsN,
  output logic             ale,
  output logic             aleN,
  output logic [1:0]       aHi,
  output logic [LANES-1:0] beOut
);
  ctlStb_t stb;
  logic    reqOk, lastBeat;

  mbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOk(reqOk), .lastBeat(lastBeat),
    .rdy(rdy), .halt(halt), .holdReq(holdReq), .stb(stb), .reqAck(reqAck),
    .reqErr(reqErr), .adsN(adsN), .ale(ale), .aleN(aleN), .ctlOe(ctlOe)
  );

  mbus_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqWidth(reqWidth), .reqLen(reqLen), .wrData(wrData), .busAdIn(busAdIn),
    .reqOk(reqOk), .lastBeat(lastBeat), .wrNext(wrNext), .busAd(busAd),
    .busAdOe(busAdOe), .aHi(aHi), .beOut(beOut), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/mbus_chk.sv
module mbus_chk (
  input logic clk,
  input logic rstN,
  input logic adsN,
  input logic ale,
  input logic aleN,
  input logic rdy,
  input logic rdValid,
  input logic reqAck,
  input logic reqErr,
  input logic wrNext,
  input logic busAdOe,
  input logic ctlOe
);
  AST_ADS_SINGLE: assert property (@(posedge clk) disable iff (!rstN) !adsN |=> adsN); // R2
  AST_ALE_MATCH: assert property (@(posedge clk) disable iff (!rstN) (ale == !adsN) && (aleN != ale)); // R2
  AST_ADDR_DRIVEN: assert property (@(posedge clk) disable iff (!rstN) !adsN |-> busAdOe && ctlOe); // R1
  AST_WRNEXT_ON_RDY: assert property (@(posedge clk) disable iff (!rstN) wrNext |-> rdy && busAdOe); // R5
  AST_RDVALID_AFTER_RDY: assert property (@(posedge clk) disable iff (!rstN) rdValid |-> $past(rdy)); // R6
  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN) reqErr |-> reqAck ##1 adsN); // R7
  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rstN) !ctlOe |=> adsN); // R11
endmodule

bind mbus_master mbus_chk u_chk (.*);

// File: tb/mbus_master_tb.sv
module mbus_master_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, halt = 0, holdReq = 0, rdy = 0;
  logic [31:0] reqAddr = '0, wrData = '0, busAdIn = '0;
  logic [1:0] reqWidth = 2'd2, reqLen = '0;
  logic reqAck, reqErr, wrNext, rdValid, busAdOe, ctlOe, adsN, ale, aleN;
  logic [31:0] rdData, busAd;
  logic [1:0] aHi;
  logic [3:0] beOut;
  int nChecks = 0, nFails = 0;
  logic [31:0] lastHalt = '0;

  always #4 clk = ~clk;

  mbus_master u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int stepB(input logic [1:0] w);
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
  endfunction
  function automatic logic [3:0] alignB(input logic [3:0] a, input logic [1:0] w);
    return (w == 2'd0) ? a : (w == 2'd1) ? {a[3:1], 1'b0} : {a[3:2], 2'b00};
  endfunction
  function automatic logic [31:0] maskB(input logic [1:0] w);
    return (w == 2'd0) ? 32'hFF : (w == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [3:0] beB(input logic [1:0] w, input logic [3:0] p);
    return (w == 2'd0) ? {2'b00, p[1:0]} : (w == 2'd1) ? {2'b00, p[1], 1'b0} : 4'b0000;
  endfunction

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic runTxn(input logic [31:0] addr, input logic wr, input logic [1:0] w,
                        input logic [1:0] len, input bit haltMid);
    logic [31:0] wd[4], rv[4], tmp;
    logic [3:0] st0, part;
    bit bad;
    for (int b = 0; b < 4; b++) begin wd[b] = $urandom; rv[b] = $urandom; end
    st0  = alignB(addr[3:0], w);
    part = st0;
    bad  = (int'(st0) + (int'(len) + 1) * stepB(w)) > 16;
    @(negedge clk);
    reqValid = 1; reqAddr = addr; reqWrite = wr; reqWidth = w; reqLen = len; wrData = wd[0];
    #1 chk("R7 ack", reqAck, 1);
    chk("R7 err", reqErr, bad);
    @(negedge clk);
    reqValid = 0;
    if (bad) begin #1 chk("R7 no address cycle", adsN, 1); return; end
    #1 chk("R1 address word", busAd, {addr[31:2], len});
    chk("R1 oe", busAdOe, 1);
    chk("R2 strobes", {adsN, ale, aleN}, 3'b010);
    chk("R4 aHi start", aHi, st0[3:2]);
    chk("R4 beOut start", beOut, beB(w, st0));
    if (haltMid) halt = 1;
    @(negedge clk);
    for (int b = 0; b <= int'(len); b++) begin
      part = st0 + 4'(b * stepB(w));
      repeat ($urandom % 3) begin
        #1 chk("R2 strobes idle in data", {adsN, ale}, 2'b10);
        chk("R4 aHi hold", aHi, part[3:2]);
        @(negedge clk);
      end
      rdy = 1; busAdIn = rv[b]; wrData = wd[b];
      #1 chk("R4 aHi beat", aHi, part[3:2]);
      chk("R4 beOut beat", beOut, beB(w, part));
      if (wr) begin
        chk("R5 write lanes", busAd, wd[b] & maskB(w));
        chk("R5 wrNext", wrNext, 1);
      end
      @(negedge clk);
      rdy = 0;
      #1 if (!wr) begin
        chk("R6 rdValid", rdValid, 1);
        chk("R6 rdData", rdData, rv[b] & maskB(w));
      end
    end
    tmp = wd[len] & maskB(w);
    lastHalt = wr ? {tmp[31:2], len} : {addr[31:4], part[3:2], len};
    if (haltMid) begin
      chk("R10 halt after burst oe", busAdOe, 1);
      chk("R10 halt after burst value", busAd, lastHalt);
      halt = 0;
      @(negedge clk);
      #1 chk("R10 leave halt", busAdOe, 0);
    end else begin
      chk("R3 idle after burst", {adsN, busAdOe}, 2'b10);
    end
  endtask

  task automatic haltIdle(input string req);
    @(negedge clk); halt = 1;
    @(negedge clk);
    #1 chk(req, busAd, lastHalt);
    chk("R10 halt oe", busAdOe, 1);
    halt = 0;
    @(negedge clk);
    #1 chk("R10 halt exit", busAdOe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishUp();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1 chk("R2 reset strobes", {adsN, ale, aleN}, 3'b101);
    chk("R3 reset bus oe", busAdOe, 0);
    chk("R11 reset ctlOe", ctlOe, 1);
    rstN = 1;
    runTxn(32'h0000_1000, 1, 2'd2, 2'd3, 0);
    haltIdle("R8 halt after write");
    runTxn(32'h0000_2A4C, 0, 2'd0, 2'd3, 0);
    haltIdle("R9 halt after read");
    runTxn(32'h0000_300A, 0, 2'd1, 2'd2, 1);
    runTxn(32'h0000_4008, 1, 2'd2, 2'd3, 0);
    runTxn(32'h0000_500F, 0, 2'd0, 2'd1, 0);
    runTxn(32'h0000_600C, 1, 2'd1, 2'd1, 0);
    haltIdle("R8 halt after 16-bit write");

    @(negedge clk);
    holdReq = 1; reqValid = 1; reqAddr = 32'h80; reqWidth = 2'd2; reqLen = 2'd0;
    #1 chk("R11 ctlOe off", ctlOe, 0);
    chk("R11 no ack", reqAck, 0);
    @(negedge clk);
    #1 chk("R11 no address cycle", adsN, 1);
    holdReq = 0; reqValid = 0;
    @(negedge clk);
    #1 chk("R11 ctlOe back", ctlOe, 1);

    @(negedge clk);
    reqValid = 1; reqAddr = 32'h0000_7000; reqWrite = 1; reqWidth = 2'd2; reqLen = 2'd0;
    wrData = 32'h1234_5678;
    #1 chk("R3 first ack", reqAck, 1);
    @(negedge clk);
    reqAddr = 32'h0000_8004; reqWrite = 0; reqLen = 2'd1;
    #1 chk("R3 no ack in address cycle", reqAck, 0);
    @(negedge clk);
    rdy = 1;
    #1 chk("R3 ack at last beat", reqAck, 1);
    @(negedge clk);
    rdy = 0; reqValid = 0;
    #1 chk("R3 back-to-back strobe", adsN, 0);
    chk("R3 back-to-back address", busAd, {30'(32'h0000_8004 >> 2), 2'd1});
    @(negedge clk);
    rdy = 1;
    repeat (2) @(negedge clk);
    rdy = 0;
    #1 chk("R3 idle after second", adsN, 1);

    for (int t = 0; t < 40; t++) begin
      logic [1:0] w;
      w = 2'($urandom % 3);
      runTxn($urandom, 1'($urandom), w, 2'($urandom), ($urandom % 5) == 0);
      if (t % 8 == 7) haltIdle("R8 R9 halt random");
    end
    finishUp();
  end
endmodule